// File: doc/BRIEF.md
# Half-to-Single Float Widening Converter

This block takes a 16-bit half-precision floating-point value and returns the 32-bit single-precision value that is numerically equal to it. Every half-precision value has an exact single-precision equivalent, so the block never rounds. It handles signed zeros and normals. It renormalises subnormals into single-precision normals. It maps infinities and NaNs to their single-precision forms. When the input is a signaling NaN, it raises an invalid-operation flag.

A per-transfer mode input selects between two readings of the top exponent code. The standard reading uses that code for infinity and NaN. The alternative reading has no infinity or NaN: it treats stored exponent 31 as an ordinary normal exponent, which reaches magnitudes from 65536 up to 131008. The input side uses a valid/ready handshake. One register stage holds the result and keeps it steady while the consumer stalls.

Top module: `hcvt_widen`

## Requirements
- R1: An input with stored exponent 0 (bits 14:10) and fraction 0 (bits 9:0) gives a single-precision zero with the same sign (bit 15 to bit 31), all other bits zero.
- R2: An input with stored exponent 1 to 30 gives the same sign, single-precision exponent (bits 30:23) equal to the stored exponent plus 112, and the 10 fraction bits placed in bits 22:13 with bits 12:0 zero (0x3C00 gives 0x3F800000, 0x7BFF gives 0x477FE000, 0xC000 gives 0xC0000000).
- R3: An input with stored exponent 0 and a nonzero fraction gives a single-precision normal. Its exponent is 112 minus the number of leading zeros in the 10-bit fraction. The remaining fraction bits, left-aligned below the hidden one, fill the result fraction (0x0001 gives 0x33800000).
- R4: In standard mode (mode input 0), stored exponent 31 with fraction 0 gives a signed infinity (0x7C00 gives 0x7F800000, 0xFC00 gives 0xFF800000).
- R5: In standard mode, stored exponent 31 with a nonzero fraction gives a NaN with the same sign, exponent 0xFF, and the input fraction in bits 22:13 with bit 22 forced to 1. The invalid flag is 1 exactly when input fraction bit 9 was 0.
- R6: In alternative mode (mode input 1), stored exponent 31 is rebiased like any normal exponent (result exponent 143), and the invalid flag is always 0. All other encodings convert the same as in standard mode.
- R7: The output register loads only in a cycle where in_valid and in_ready are both 1. in_ready is 1 when the register is empty or out_ready is 1. With out_ready 1 and no new transfer, out_valid falls on the next clock and out_result keeps its last value.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_result and out_invalid hold their values.
- R9: A synchronous active-high reset clears out_valid, out_result and out_invalid to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Block can accept a value this cycle |
| in_half | input | 16 | Half-precision operand |
| in_alt | input | 1 | 1 selects the alternative reading of exponent 31 |
| out_valid | output | 1 | out_result holds a converted value |
| out_ready | input | 1 | Consumer accepts the result |
| out_result | output | 32 | Single-precision result |
| out_invalid | output | 1 | Invalid-operation flag for the held result |

## Verification
Subnormals are the main target: the smallest, the largest, one with only the top fraction bit set, and one with two low bits set. An off-by-one leading-zero count would shift the exponent by a power of two, and a design that kept the hidden bit would corrupt the fraction MSB. NaNs with the quiet bit clear and set, in both signs, show whether the payload is moved and the quiet bit forced, and whether the flag tracks only signaling inputs. The exponent-31 codes run under both modes; a design that ignored the mode would return infinities where 65536 and 131008 are expected. A stall with a second value waiting shows whether a design overwrites its held result or drops the waiting value.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;

    localparam int H_EXP_W   = 5;
    localparam int H_FRAC_W  = 10;
    localparam int H_WIDTH   = 1 + H_EXP_W + H_FRAC_W;
    localparam int S_EXP_W   = 8;
    localparam int S_FRAC_W  = 23;
    localparam int S_WIDTH   = 1 + S_EXP_W + S_FRAC_W;
    localparam int H_BIAS    = (1 << (H_EXP_W - 1)) - 1;
    localparam int S_BIAS    = (1 << (S_EXP_W - 1)) - 1;
    localparam int REBIAS    = S_BIAS - H_BIAS;
    localparam int FRAC_PAD  = S_FRAC_W - H_FRAC_W;
    localparam int LZ_W      = $clog2(H_FRAC_W);

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUBNORM,
        CLS_NORMAL,
        CLS_INF,
        CLS_NAN
    } hclass_e;

    typedef struct packed {
        logic                sign;
        logic [H_EXP_W-1:0]  exp;
        logic [H_FRAC_W-1:0] frac;
    } half_t;

    typedef struct packed {
        logic                sign;
        logic [S_EXP_W-1:0]  exp;
        logic [S_FRAC_W-1:0] frac;
    } single_t;

    typedef struct packed {
        single_t value;
        logic    invalid;
    } result_t;

    function automatic logic exp_saturated(input logic [H_EXP_W-1:0] e);
        return &e;
    endfunction

    function automatic logic [S_FRAC_W-1:0] widen_frac(input logic [H_FRAC_W-1:0] f);
        return {f, {FRAC_PAD{1'b0}}};
    endfunction

endpackage

// File: rtl/hcvt_classify.sv
module hcvt_classify
    import hcvt_pkg::*;
(
    input  half_t   op,
    input  logic    alt_mode,
    output hclass_e cls
);
    logic exp_zero;
    logic frac_zero;
    logic exp_top;

    assign exp_zero  = (op.exp == '0);
    assign frac_zero = (op.frac == '0);
    assign exp_top   = exp_saturated(op.exp);

    always_comb begin
        if (exp_zero) begin
            cls = frac_zero ? CLS_ZERO : CLS_SUBNORM;
        end else if (exp_top && !alt_mode) begin
            cls = frac_zero ? CLS_INF : CLS_NAN;
        end else begin
            cls = CLS_NORMAL;
        end
    end
endmodule

// File: rtl/hcvt_lzc.sv
module hcvt_lzc #(
    parameter int W  = 10,
    parameter int CW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                count = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/hcvt_assemble.sv
module hcvt_assemble
    import hcvt_pkg::*;
(
    input  half_t             op,
    input  hclass_e           cls,
    input  logic [LZ_W-1:0]   lead_zeros,
    output result_t           res
);
    logic [H_FRAC_W-1:0] shifted;
    logic [H_FRAC_W-1:0] sub_frac;
    logic [S_EXP_W-1:0]  norm_exp;
    logic [S_EXP_W-1:0]  sub_exp;
    logic [H_FRAC_W-1:0] nan_frac;

    assign shifted  = op.frac << lead_zeros;
    assign sub_frac = {shifted[H_FRAC_W-2:0], 1'b0};
    assign norm_exp = S_EXP_W'(op.exp) + S_EXP_W'(REBIAS);
    assign sub_exp  = S_EXP_W'(REBIAS) - S_EXP_W'(lead_zeros);
    assign nan_frac = {1'b1, op.frac[H_FRAC_W-2:0]};

    always_comb begin
        res.value.sign = op.sign;
        res.value.exp  = '0;
        res.value.frac = '0;
        res.invalid    = 1'b0;
        unique case (cls)
            CLS_ZERO: begin
                res.value.exp  = '0;
                res.value.frac = '0;
            end
            CLS_SUBNORM: begin
                res.value.exp  = sub_exp;
                res.value.frac = widen_frac(sub_frac);
            end
            CLS_NORMAL: begin
                res.value.exp  = norm_exp;
                res.value.frac = widen_frac(op.frac);
            end
            CLS_INF: begin
                res.value.exp  = '1;
                res.value.frac = '0;
            end
            CLS_NAN: begin
                res.value.exp  = '1;
                res.value.frac = widen_frac(nan_frac);
                res.invalid    = ~op.frac[H_FRAC_W-1];
            end
            default: begin
                res.value.exp  = '0;
                res.value.frac = '0;
            end
        endcase
    end
endmodule

// File: rtl/hcvt_widen.sv
module hcvt_widen
    import hcvt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [H_WIDTH-1:0] in_half,
    input  logic               in_alt,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [S_WIDTH-1:0] out_result,
    output logic               out_invalid
);
    half_t           op;
    hclass_e         cls;
    logic [LZ_W-1:0] lead_zeros;
    result_t         conv;
    result_t         held;
    logic            take;

    assign op = half_t'(in_half);

    hcvt_classify u_classify (
        .op       (op),
        .alt_mode (in_alt),
        .cls      (cls)
    );

    hcvt_lzc #(.W(H_FRAC_W), .CW(LZ_W)) u_lzc (
        .vec   (op.frac),
        .count (lead_zeros)
    );

    hcvt_assemble u_assemble (
        .op         (op),
        .cls        (cls),
        .lead_zeros (lead_zeros),
        .res        (conv)
    );

    assign in_ready = ~out_valid | out_ready;
    assign take     = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            held      <= '0;
        end else begin
            if (take) begin
                out_valid <= 1'b1;
                held      <= conv;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    assign out_result  = held.value;
    assign out_invalid = held.invalid;
endmodule

// File: rtl/hcvt_widen_chk.sv
module hcvt_widen_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [15:0] in_half,
    input logic        in_alt,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_result,
    input logic        out_invalid
);
    logic fire;
    assign fire = in_valid && in_ready;

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == 32'h0 && !out_invalid));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_invalid)));

    assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_fire_fills_R7: assert property (@(posedge clk) disable iff (rst)
        fire |=> out_valid);

    assert_normal_rebias_R2: assert property (@(posedge clk) disable iff (rst)
        (fire && in_half[14:10] != 5'd0 && in_half[14:10] != 5'd31)
        |=> (out_result[30:23] == {3'b000, $past(in_half[14:10])} + 8'd112));

    assert_sub_range_R3: assert property (@(posedge clk) disable iff (rst)
        (fire && in_half[14:10] == 5'd0 && in_half[9:0] != 10'd0)
        |=> (out_result[30:23] >= 8'd103 && out_result[30:23] <= 8'd112));

    assert_nan_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_result[30:23] == 8'hFF && out_result[22:0] != 23'd0) |-> out_result[22]);

    assert_flag_nan_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_invalid) |-> (out_result[30:22] == 9'h1FF));

    assert_alt_noflag_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && in_alt) |=> !out_invalid);
endmodule

bind hcvt_widen hcvt_widen_chk u_chk (.*);

// File: tb/tb_hcvt_widen.sv
`timescale 1ns/1ps
module tb_hcvt_widen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_half = 16'h0;
    logic        in_alt = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_result;
    logic        out_invalid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hcvt_widen dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_half(in_half), .in_alt(in_alt),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_result(out_result), .out_invalid(out_invalid)
    );

    // {req[3:0], alt, half[15:0], single[31:0], invalid}
    localparam int NV = 22;
    localparam logic [53:0] VEC [NV] = '{
        {4'd1, 1'b0, 16'h0000, 32'h00000000, 1'b0},
        {4'd1, 1'b0, 16'h8000, 32'h80000000, 1'b0},
        {4'd2, 1'b0, 16'h3C00, 32'h3F800000, 1'b0},
        {4'd2, 1'b0, 16'hC000, 32'hC0000000, 1'b0},
        {4'd2, 1'b0, 16'h7BFF, 32'h477FE000, 1'b0},
        {4'd2, 1'b0, 16'h0400, 32'h38800000, 1'b0},
        {4'd2, 1'b0, 16'h3555, 32'h3EAAA000, 1'b0},
        {4'd3, 1'b0, 16'h0001, 32'h33800000, 1'b0},
        {4'd3, 1'b0, 16'h03FF, 32'h387FC000, 1'b0},
        {4'd3, 1'b0, 16'h8200, 32'hB8000000, 1'b0},
        {4'd3, 1'b0, 16'h0003, 32'h34400000, 1'b0},
        {4'd4, 1'b0, 16'h7C00, 32'h7F800000, 1'b0},
        {4'd4, 1'b0, 16'hFC00, 32'hFF800000, 1'b0},
        {4'd5, 1'b0, 16'h7E00, 32'h7FC00000, 1'b0},
        {4'd5, 1'b0, 16'h7C01, 32'h7FC02000, 1'b1},
        {4'd5, 1'b0, 16'hFD55, 32'hFFEAA000, 1'b1},
        {4'd6, 1'b1, 16'h7C00, 32'h47800000, 1'b0},
        {4'd6, 1'b1, 16'h7FFF, 32'h47FFE000, 1'b0},
        {4'd6, 1'b1, 16'hFC00, 32'hC7800000, 1'b0},
        {4'd6, 1'b1, 16'h7C01, 32'h47802000, 1'b0},
        {4'd6, 1'b1, 16'h3C00, 32'h3F800000, 1'b0},
        {4'd6, 1'b1, 16'h0001, 32'h33800000, 1'b0}
    };

    function automatic string req_name(input logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: state during reset
        check("R9", "out_valid in reset", {31'd0, out_valid}, 32'd0);
        check("R9", "out_result in reset", out_result, 32'd0);
        check("R9", "out_invalid in reset", {31'd0, out_invalid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R7", "in_ready when empty", {31'd0, in_ready}, 32'd1);

        // R1..R6 vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_alt   = VEC[i][49];
            in_half  = VEC[i][48:33];
            @(negedge clk);
            in_valid = 1'b0;
            check(req_name(VEC[i][53:50]), "out_valid", {31'd0, out_valid}, 32'd1);
            check(req_name(VEC[i][53:50]), "out_result", out_result, VEC[i][32:1]);
            check(req_name(VEC[i][53:50]), "out_invalid", {31'd0, out_invalid}, {31'd0, VEC[i][0]});
        end
        in_alt = 1'b0;

        // R7/R8: stall with a second value waiting
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_half   = 16'h3C00;
        @(negedge clk);
        check("R7", "first value loaded", out_result, 32'h3F800000);
        check("R7", "in_ready low while stalled", {31'd0, in_ready}, 32'd0);
        in_half = 16'hC000;
        @(negedge clk);
        check("R8", "held result during stall", out_result, 32'h3F800000);
        check("R8", "out_valid during stall", {31'd0, out_valid}, 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        check("R7", "waiting value taken after stall", out_result, 32'hC0000000);
        in_valid = 1'b0;
        @(negedge clk);
        check("R7", "out_valid drops when drained", {31'd0, out_valid}, 32'd0);
        check("R7", "result kept after drain", out_result, 32'hC0000000);
        in_half = 16'h7C00;
        @(negedge clk);
        check("R7", "no load without in_valid", out_result, 32'hC0000000);
        check("R7", "out_valid stays low", {31'd0, out_valid}, 32'd0);

        // R9: reset in mid-run clears a held signaling-NaN result
        in_valid = 1'b1;
        in_half  = 16'h7C01;
        @(negedge clk);
        check("R5", "flag before reset", {31'd0, out_invalid}, 32'd1);
        in_valid = 1'b0;
        rst      = 1'b1;
        @(negedge clk);
        check("R9", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        check("R9", "out_result after reset", out_result, 32'd0);
        check("R9", "out_invalid after reset", {31'd0, out_invalid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule